// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

A register-mapped general-purpose I/O block for up to 64 pins, organised as two 32-pin banks. Software sets each pin's direction and driven level, reads the synchronised level of every pin, and arms an edge-interrupt unit. For each pin, that unit holds an enable bit, a single edge-polarity bit, a sticky pending bit and a wake-select bit. Pin inputs cross into the clock domain through a two-flop synchroniser. An edge is found by comparing two consecutive synchronised samples.

A pending bit latches on the selected edge whether or not the pin's interrupt is enabled. Software clears pending bits by writing ones to them. The combined interrupt line is the OR of pending bits gated by the enable bits. The wake line is the OR of pending bits gated by the wake-select bits, and it is independent of the interrupt enable. Reads return data one cycle after the read strobe. Writes take effect at the clock edge that samples the write strobe.

Top module: `gpio_edge_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, all pins are inputs (`pin_oe` = 0), and `pin_out`, `irq` and `wake` are 0.
- R2: The direction word at byte offset 0x00 (1 = output) drives `pin_oe`. The level word at 0x18 drives `pin_out`. Both read back as written. Pins 32 and up use the word 4 bytes higher (0x04, 0x1C). `pin_oe` changes only after a register write.
- R3: The input word at 0x10 (0x14 for pins 32 and up) shows each pin after two synchronising flops. A pin changed just after clock edge P0 is first seen by a read whose strobe is sampled at edge P3. Writes to this word have no effect.
- R4: Bits for pins at or above NUM_PINS read as zero, and writes to them are discarded.
- R5: With polarity bit 0, a rising edge on a pin sets its pending bit. A falling edge does not set it.
- R6: With polarity bit 1, a falling edge sets the pending bit. A rising edge does not set it.
- R7: Writing 1 to a pending bit at 0x50/0x54 clears it. Writing 0 leaves it unchanged. No other event clears a pending bit.
- R8: If an edge and a clearing write hit the same pending bit in the same cycle, the bit stays set.
- R9: Pending bits latch regardless of the enable word (0x40/0x44). `irq` is 1 exactly when some pending bit has its enable bit set.
- R10: `wake` is 1 exactly when some pending bit has its wake-select bit set (0x58/0x5C). The wake-select bits work independently of the interrupt enable bits.
- R11: Changing a polarity bit (0x48/0x4C) while the pin is steady never sets a pending bit.
- R12: The interrupt words sit at 0x40 (enable), 0x48 (polarity), 0x50 (pending) and 0x58 (wake), each with a high-bank word 4 bytes above. Unmapped offsets such as 0x08 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 7 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_oe | output | NUM_PINS | Per-pin output enable |
| pin_out | output | NUM_PINS | Per-pin driven level |
| irq | output | 1 | Combined enabled-pending interrupt |
| wake | output | 1 | Combined wake-selected pending line |

## Verification
A register table first exercises read-back of every mapped word, masking of the pins that do not exist, the read-only input word and the unmapped holes. This separates address-decode faults from storage faults. Directed pin waveforms then drive rising and falling edges under both polarity settings, which separates the wrong-edge fault from the missed-edge fault. Enable and wake selection are toggled around a latched pending bit, which shows whether latching depends on the enable bit. Three cycle-exact stimuli remain: counting the synchroniser latency through successive reads, aiming a clearing write at the exact cycle a new edge is registered, and flipping polarity on a steady pin. These expose wrong clear priority and spurious detection.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

   localparam int BANK_W    = 32;
   localparam int MAX_BANKS = 2;
   localparam int SLOT_W    = BANK_W * MAX_BANKS;
   localparam int ADDR_W    = 7;

   // register selector, address bits [4:3]
   localparam logic [1:0] DSEL_DIR  = 2'b00;
   localparam logic [1:0] DSEL_HOLE = 2'b01;
   localparam logic [1:0] DSEL_LVL  = 2'b10;
   localparam logic [1:0] DSEL_DRV  = 2'b11;

   localparam logic [1:0] ISEL_ARM  = 2'b00;
   localparam logic [1:0] ISEL_POL  = 2'b01;
   localparam logic [1:0] ISEL_PEND = 2'b10;
   localparam logic [1:0] ISEL_WAKE = 2'b11;

   // bits of bank 'bank' that map to existing pins
   function automatic logic [BANK_W-1:0] bank_mask(input int pins, input int bank);
      int n;
      n = pins - bank * BANK_W;
      if (n >= BANK_W)
         return '1;
      else if (n <= 0)
         return '0;
      else
         return (BANK_W'(1) << n) - BANK_W'(1);
   endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
   parameter int WIDTH  = 36,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o,
   output logic [WIDTH-1:0] prev_o
);

   localparam int TAPS = STAGES + 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_pin_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("gpio_pin_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] tap_q [TAPS];

   for (genvar s = 0; s < TAPS; s++) begin : g_tap
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tap_q[s] <= '0;
            else        tap_q[s] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tap_q[s] <= '0;
            else        tap_q[s] <= tap_q[s-1];
         end
      end
   end

   // last synchroniser stage and one more sample for edge comparison
   assign sync_o = tap_q[STAGES-1];
   assign prev_o = tap_q[STAGES];

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
   import gpio_edge_pkg::*;
#(
   parameter logic [BANK_W-1:0] VALID = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] sync_i,
   input  logic [BANK_W-1:0] prev_i,
   input  logic              we_dir,
   input  logic              we_drv,
   input  logic              we_arm,
   input  logic              we_pol,
   input  logic              we_pend,
   input  logic              we_wake,
   input  logic [BANK_W-1:0] wdata,
   output logic [BANK_W-1:0] dir_o,
   output logic [BANK_W-1:0] drv_o,
   output logic [BANK_W-1:0] arm_o,
   output logic [BANK_W-1:0] pol_o,
   output logic [BANK_W-1:0] pend_o,
   output logic [BANK_W-1:0] wake_sel_o,
   output logic              irq_o,
   output logic              wake_o
);

   logic [BANK_W-1:0] dir_q, drv_q, arm_q, pol_q, pend_q, wsel_q;
   logic [BANK_W-1:0] rise, fall, hit, clr, pend_d;

   // edge detection between consecutive synchronised samples
   assign rise   = sync_i & ~prev_i;
   assign fall   = ~sync_i & prev_i;
   assign hit    = ((rise & ~pol_q) | (fall & pol_q)) & VALID;
   assign clr    = we_pend ? wdata : '0;
   assign pend_d = ((pend_q & ~clr) | hit) & VALID;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         drv_q  <= '0;
         arm_q  <= '0;
         pol_q  <= '0;
         pend_q <= '0;
         wsel_q <= '0;
      end else begin
         if (we_dir)  dir_q  <= wdata & VALID;
         if (we_drv)  drv_q  <= wdata & VALID;
         if (we_arm)  arm_q  <= wdata & VALID;
         if (we_pol)  pol_q  <= wdata & VALID;
         if (we_wake) wsel_q <= wdata & VALID;
         pend_q <= pend_d;
      end
   end

   assign dir_o      = dir_q;
   assign drv_o      = drv_q;
   assign arm_o      = arm_q;
   assign pol_o      = pol_q;
   assign pend_o     = pend_q;
   assign wake_sel_o = wsel_q;
   assign irq_o      = |(pend_q & arm_q);
   assign wake_o     = |(pend_q & wsel_q);

   // a pending bit only drops when a one was written to it
   assert_clear_by_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((($past(pend_q) & ~pend_q) & ~$past(clr)) == '0));

   // every detected edge is pending next cycle, even under a clear
   assert_edge_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(hit) & ~pend_q) == '0));

   // no new pending bit on a pin whose samples did not differ
   assert_no_spurious_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_q & ~$past(pend_q) & ~$past(sync_i ^ prev_i)) == '0));

endmodule

// File: rtl/gpio_edge_irq_ctrl.sv
module gpio_edge_irq_ctrl
   import gpio_edge_pkg::*;
#(
   parameter int NUM_PINS    = 36,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [BANK_W-1:0]   reg_wdata,
   input  logic                reg_wr,
   input  logic                reg_rd,
   output logic [BANK_W-1:0]   reg_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic [NUM_PINS-1:0] pin_out,
   output logic                irq,
   output logic                wake
);

   localparam int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;

   if (NUM_PINS < 1 || NUM_PINS > SLOT_W) begin : g_bad_pins
      $error("gpio_edge_irq_ctrl: NUM_PINS out of range");
   end

   // ---------------- input synchronisation ----------------
   logic [NUM_PINS-1:0] sync_n, prev_n;
   logic [SLOT_W-1:0]   sync_pad, prev_pad;

   gpio_pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (pin_in),
      .sync_o  (sync_n),
      .prev_o  (prev_n)
   );

   assign sync_pad = SLOT_W'(sync_n);
   assign prev_pad = SLOT_W'(prev_n);

   // ---------------- address decode ----------------
   logic       in_irq, aligned;
   logic [1:0] sel;
   logic       bsel;

   assign in_irq  = reg_addr[6];
   assign aligned = (reg_addr[5] == 1'b0) && (reg_addr[1:0] == 2'b00);
   assign sel     = reg_addr[4:3];
   assign bsel    = reg_addr[2];

   // ---------------- banks ----------------
   logic [BANK_W-1:0] dir_s  [MAX_BANKS];
   logic [BANK_W-1:0] drv_s  [MAX_BANKS];
   logic [BANK_W-1:0] arm_s  [MAX_BANKS];
   logic [BANK_W-1:0] pol_s  [MAX_BANKS];
   logic [BANK_W-1:0] pend_s [MAX_BANKS];
   logic [BANK_W-1:0] wsel_s [MAX_BANKS];
   logic [BANK_W-1:0] lvl_s  [MAX_BANKS];
   logic [MAX_BANKS-1:0] irq_s, wake_s;

   for (genvar b = 0; b < MAX_BANKS; b++) begin : g_bank
      localparam logic [BANK_W-1:0] MASK = bank_mask(NUM_PINS, b);
      if (b < NUM_BANKS) begin : g_live
         logic hit_b, wr_d, wr_i;
         assign hit_b = aligned && (int'(bsel) == b);
         assign wr_d  = reg_wr && hit_b && !in_irq;
         assign wr_i  = reg_wr && hit_b && in_irq;
         assign lvl_s[b] = sync_pad[b*BANK_W +: BANK_W] & MASK;

         gpio_edge_bank #(.VALID(MASK)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .sync_i     (sync_pad[b*BANK_W +: BANK_W]),
            .prev_i     (prev_pad[b*BANK_W +: BANK_W]),
            .we_dir     (wr_d && (sel == DSEL_DIR)),
            .we_drv     (wr_d && (sel == DSEL_DRV)),
            .we_arm     (wr_i && (sel == ISEL_ARM)),
            .we_pol     (wr_i && (sel == ISEL_POL)),
            .we_pend    (wr_i && (sel == ISEL_PEND)),
            .we_wake    (wr_i && (sel == ISEL_WAKE)),
            .wdata      (reg_wdata),
            .dir_o      (dir_s[b]),
            .drv_o      (drv_s[b]),
            .arm_o      (arm_s[b]),
            .pol_o      (pol_s[b]),
            .pend_o     (pend_s[b]),
            .wake_sel_o (wsel_s[b]),
            .irq_o      (irq_s[b]),
            .wake_o     (wake_s[b])
         );
      end else begin : g_absent
         assign dir_s[b]  = '0;
         assign drv_s[b]  = '0;
         assign arm_s[b]  = '0;
         assign pol_s[b]  = '0;
         assign pend_s[b] = '0;
         assign wsel_s[b] = '0;
         assign lvl_s[b]  = '0;
         assign irq_s[b]  = 1'b0;
         assign wake_s[b] = 1'b0;
      end
   end

   // ---------------- pin and line outputs ----------------
   logic [SLOT_W-1:0] dir_all, drv_all, arm_all, wsel_all;

   always_comb begin
      for (int b = 0; b < MAX_BANKS; b++) begin
         dir_all [b*BANK_W +: BANK_W] = dir_s[b];
         drv_all [b*BANK_W +: BANK_W] = drv_s[b];
         arm_all [b*BANK_W +: BANK_W] = arm_s[b];
         wsel_all[b*BANK_W +: BANK_W] = wsel_s[b];
      end
   end

   assign pin_oe  = dir_all[NUM_PINS-1:0];
   assign pin_out = drv_all[NUM_PINS-1:0];
   assign irq     = |irq_s;
   assign wake    = |wake_s;

   // ---------------- read path ----------------
   logic [BANK_W-1:0] rd_word;

   always_comb begin
      rd_word = '0;
      if (aligned) begin
         if (in_irq) begin
            unique case (sel)
               ISEL_ARM:  rd_word = arm_s[bsel];
               ISEL_POL:  rd_word = pol_s[bsel];
               ISEL_PEND: rd_word = pend_s[bsel];
               default:   rd_word = wsel_s[bsel];
            endcase
         end else begin
            unique case (sel)
               DSEL_DIR:  rd_word = dir_s[bsel];
               DSEL_LVL:  rd_word = lvl_s[bsel];
               DSEL_DRV:  rd_word = drv_s[bsel];
               default:   rd_word = '0;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (reg_rd) reg_rdata <= rd_word;
   end

   // ---------------- assertions ----------------
   assert_irq_needs_arm_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (|arm_all));

   assert_wake_needs_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> (|wsel_all));

   assert_dir_moves_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pin_oe) |-> $past(reg_wr));

endmodule

// File: tb/gpio_edge_irq_ctrl_bench.sv
module gpio_edge_irq_ctrl_bench;

   localparam int NP = 36;

   typedef struct packed {
      logic        rd;
      logic [6:0]  addr;
      logic [31:0] data;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 7'h00, 32'hA5A5_0F0F, 4'd2},  // R2 direction low
      '{1'b1, 7'h00, 32'hA5A5_0F0F, 4'd2},
      '{1'b0, 7'h18, 32'h1234_5678, 4'd2},  // R2 level low
      '{1'b1, 7'h18, 32'h1234_5678, 4'd2},
      '{1'b0, 7'h04, 32'hFFFF_FFFF, 4'd4},  // R4 direction high, 4 pins
      '{1'b1, 7'h04, 32'h0000_000F, 4'd4},
      '{1'b0, 7'h1C, 32'hFFFF_FFFF, 4'd4},  // R4 level high
      '{1'b1, 7'h1C, 32'h0000_000F, 4'd4},
      '{1'b0, 7'h08, 32'hFFFF_FFFF, 4'd12}, // R12 hole
      '{1'b1, 7'h08, 32'h0000_0000, 4'd12},
      '{1'b0, 7'h10, 32'hFFFF_FFFF, 4'd3},  // R3 input word read-only
      '{1'b1, 7'h10, 32'h0000_0000, 4'd3},
      '{1'b0, 7'h40, 32'h0000_00FF, 4'd12}, // R12 enable
      '{1'b1, 7'h40, 32'h0000_00FF, 4'd12},
      '{1'b0, 7'h48, 32'h0000_00F0, 4'd12}, // R12 polarity
      '{1'b1, 7'h48, 32'h0000_00F0, 4'd12},
      '{1'b0, 7'h58, 32'h0000_0003, 4'd12}, // R12 wake
      '{1'b1, 7'h58, 32'h0000_0003, 4'd12},
      '{1'b1, 7'h50, 32'h0000_0000, 4'd12}, // R12 pending empty
      '{1'b0, 7'h4C, 32'hFFFF_FFFF, 4'd4},  // R4 polarity high
      '{1'b1, 7'h4C, 32'h0000_000F, 4'd4},
      '{1'b1, 7'h44, 32'h0000_0000, 4'd12}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [6:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic          reg_wr = 1'b0;
   logic          reg_rd = 1'b0;
   logic [31:0]   reg_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_oe, pin_out;
   logic          irq, wake;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   gpio_edge_irq_ctrl #(.NUM_PINS(NP)) u_gpio_edge_irq_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_rdata (reg_rdata),
      .pin_in    (pin_in),
      .pin_oe    (pin_oe),
      .pin_out   (pin_out),
      .irq       (irq),
      .wake      (wake)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [6:0] a, input logic [31:0] d);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd(input logic [6:0] a, output logic [31:0] d);
      reg_addr = a;
      reg_rd   = 1'b1;
      @(posedge clk);
      @(negedge clk);
      reg_rd   = 1'b0;
      d        = reg_rdata;
   endtask

   task automatic rd_chk(input string req, input logic [6:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      check(req, 64'(d), 64'(exp));
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 pin_oe", 64'(pin_oe), 64'd0);
      check("R1 pin_out", 64'(pin_out), 64'd0);
      check("R1 irq/wake", {62'd0, irq, wake}, 64'd0);
      rd_chk("R1 dir", 7'h00, 32'h0);
      rd_chk("R1 arm", 7'h40, 32'h0);
      rd_chk("R1 pol", 7'h48, 32'h0);
      rd_chk("R1 pend", 7'h50, 32'h0);
      rd_chk("R1 wake", 7'h58, 32'h0);

      // register table
      for (int i = 0; i < NV; i++) begin
         if (VECS[i].rd) begin
            rd(VECS[i].addr, d);
            n_checks++;
            if (d !== VECS[i].data) begin
               n_fail++;
               $display("FAIL R%0d vec %0d: actual %h expected %h",
                        VECS[i].req, i, d, VECS[i].data);
            end
         end else begin
            wr(VECS[i].addr, VECS[i].data);
         end
      end

      // R2 pins follow registers
      check("R2 pin_oe", 64'(pin_oe), 64'(36'hF_A5A5_0F0F));
      check("R2 pin_out", 64'(pin_out), 64'(36'hF_1234_5678));

      // clear interrupt setup
      wr(7'h40, 32'h0); wr(7'h44, 32'h0);
      wr(7'h48, 32'h0); wr(7'h4C, 32'h0);
      wr(7'h58, 32'h0); wr(7'h50, '1); wr(7'h54, '1);

      // R3 latency: captures at P1, P2, P3 after pin change
      pin_in[5] = 1'b1;
      rd_chk("R3 lat1", 7'h10, 32'h0);
      rd_chk("R3 lat2", 7'h10, 32'h0);
      rd_chk("R3 lat3", 7'h10, 32'h20);
      settle();
      wr(7'h50, '1);
      pin_in[33] = 1'b1;
      settle();
      rd_chk("R3 high input", 7'h14, 32'h2);
      rd_chk("R5 high pending", 7'h54, 32'h2);
      wr(7'h54, '1);

      // R5, R9, R7 on pin 0
      pin_in[0] = 1'b1;
      settle();
      rd_chk("R5 rise", 7'h50, 32'h1);
      check("R9 latched unarmed irq", 64'(irq), 64'd0);
      wr(7'h40, 32'h1);
      check("R9 armed irq", 64'(irq), 64'd1);
      wr(7'h50, 32'h0);
      rd_chk("R7 zero write", 7'h50, 32'h1);
      wr(7'h50, 32'h1);
      rd_chk("R7 one write", 7'h50, 32'h0);
      check("R9 irq after clear", 64'(irq), 64'd0);
      pin_in[0] = 1'b0;
      settle();
      rd_chk("R5 fall ignored", 7'h50, 32'h0);

      // R6 on pin 1
      wr(7'h48, 32'h2);
      pin_in[1] = 1'b1;
      settle();
      rd_chk("R6 rise ignored", 7'h50, 32'h0);
      pin_in[1] = 1'b0;
      settle();
      rd_chk("R6 fall", 7'h50, 32'h2);
      check("R9 unarmed bit", 64'(irq), 64'd0);

      // R10 wake
      wr(7'h58, 32'h2);
      check("R10 wake set", {62'd0, irq, wake}, 64'd1);
      wr(7'h40, 32'h2);
      check("R9 irq armed bit1", 64'(irq), 64'd1);
      wr(7'h40, 32'h0);
      check("R10 wake without arm", {62'd0, irq, wake}, 64'd1);
      wr(7'h50, 32'h2);
      check("R10 wake cleared", 64'(wake), 64'd0);
      wr(7'h58, 32'h0);
      wr(7'h48, 32'h0);

      // R11 polarity flip on steady pin
      pin_in[2] = 1'b1;
      settle();
      wr(7'h50, 32'h4);
      wr(7'h48, 32'h4);
      settle();
      wr(7'h48, 32'h0);
      settle();
      rd_chk("R11 pol flip", 7'h50, 32'h0);

      // R8 edge and clear in same cycle on pin 3
      pin_in[3] = 1'b1;
      settle();
      pin_in[3] = 1'b0;
      settle();
      rd_chk("R8 pre", 7'h50, 32'h8);
      pin_in[3] = 1'b1;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      wr(7'h50, 32'h8);
      rd_chk("R8 edge wins", 7'h50, 32'h8);
      wr(7'h50, 32'h8);
      rd_chk("R7 later clear", 7'h50, 32'h0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule